// File: doc/BRIEF.md
# MSI Vector Table P/Q State Controller

This block handles message-signalled interrupts whose per-source state is kept in a vector table in system memory, not in on-chip flops. When a source number is triggered, the controller works out where that source's 64-bit entry sits and reads the entry over a simple memory port. It then makes a two-bit pending/queued decision. The result is one of three: deliver the interrupt and mark it pending, record one queued occurrence, or drop the event. State changes are made by writing a single byte back into the entry.

Software sets up the table base, an enable, a table length in entries, an entry-size select (16 or 128 bytes) and the base interrupt number that is added to the source number. A trigger carries a force flag. A forced trigger is a resend that ignores the stored pending and queued bits. The controller handles one operation at a time and raises `busy` while it works.

The state machine has five states. `ST_IDLE` accepts a trigger that passes the checks (T_ACCEPT) and quietly ignores one that fails them (T_REJECT). `ST_FETCH` holds the read request until it is taken (T_READ_TAKEN). `ST_WAIT` waits for the response and leaves on T_ABORT (error), T_DROP (nothing to write) or T_UPDATE (a byte write is needed). `ST_WRITE` holds the byte write until it is taken and then goes on to T_SEND (pending was set) or T_DONE (queued was set). `ST_DELIVER` presents the interrupt for one cycle and returns to idle (T_DONE).

Top module: `msi_pq_ctrl`

## Requirements
- R1: The entry address is the table base plus the source number shifted left by 4, or by 7 when `cfg_wide_entry` is 1. The read request carries this address.
- R2: A trigger makes no memory access and leaves `busy` low when `cfg_tbl_en` is 0, or when the source number is greater than or equal to `cfg_tbl_len`.
- R3: The entry is big-endian: the byte at address entry+k holds bits [63-8k:56-8k]. The fields are: server in bits [63:48], with its two low bits a link pointer that is removed by shifting right by 2. Generation is bit 25 and pending (P) is bit 24, both in byte 4. Queued (Q) is bit 16, in byte 5. Priority is bits [7:0].
- R4: With P=0, Q=0 and priority 0xFF (masked), the byte 0x01 is written to entry+5 and nothing is delivered.
- R5: With P=0, Q=0 and priority other than 0xFF, the byte 0x01 | (generation<<1) is written to entry+4. After that write is accepted, the interrupt is delivered with server, priority, and irq = `cfg_irq_base` + source number.
- R6: With P=1, Q=0, the byte 0x01 is written to entry+5 and nothing is delivered.
- R7: With Q=1 (whatever P is), the event is dropped: no write and no delivery.
- R8: A trigger with `trig_force`=1 acts as if P=0 and Q=0, whatever the entry holds.
- R9: A read response with `mem_rsp_err`=1 ends the operation with no write and no delivery.
- R10: While `busy` is high, triggers are ignored and have no effect on memory or on delivery.
- R11: Only one memory request is in flight at a time. A request that is not taken keeps its valid, address and write flag unchanged until it is taken.
- R12: `dlv_valid` is a single-cycle pulse for each delivered interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_valid | input | 1 | Trigger strobe, sampled while idle |
| trig_src | input | SRC_W | Source number being triggered |
| trig_force | input | 1 | Resend: ignore the stored P/Q bits |
| busy | output | 1 | An operation is in progress |
| cfg_tbl_base | input | ADDR_W | Table base address |
| cfg_tbl_en | input | 1 | Table enable |
| cfg_tbl_len | input | SRC_W+1 | Number of valid entries |
| cfg_wide_entry | input | 1 | 1 selects 128-byte entries, 0 selects 16-byte entries |
| cfg_irq_base | input | IRQ_W | Added to the source number to form the delivered irq |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_write | output | 1 | 1 for a single-byte write, 0 for a 64-bit read |
| mem_req_addr | output | ADDR_W | Byte address of the request |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read response error |
| mem_rsp_data | input | 64 | Read data, big-endian entry |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_server | output | 14 | Target server (field shifted right by 2) |
| dlv_prio | output | 8 | Delivered priority |
| dlv_irq | output | IRQ_W | Delivered global interrupt number |

## Verification
The read request comes out in the cycle after the trigger is sampled. The bench's memory answers one cycle after taking the read. A write comes out in the cycle after the response and lands in memory on the edge where it is taken, and the delivery pulse follows in the next cycle. The bench does not count these cycles one by one. It drives each trigger on a falling edge and waits for `busy` to fall, sampling at falling edges. Only then does it compare the read address, the whole 8-byte entry and the number and content of delivery pulses it recorded. This makes the checks hold whether or not the memory stalls the requests.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

    // Controller sequencing
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_WRITE,
        ST_DELIVER
    } pq_state_e;

    // Outcome of the pending/queued decision
    typedef enum logic [1:0] {
        ACT_DROP,
        ACT_SET_Q,
        ACT_SET_P
    } pq_action_e;

    // Entry field positions (64-bit big-endian word)
    localparam int SRV_HI       = 63;
    localparam int SRV_FIELD_W  = 16;
    localparam int LINK_W       = 2;
    localparam int SRV_W        = SRV_FIELD_W - LINK_W;
    localparam int GEN_BIT      = 25;
    localparam int P_BIT        = 24;
    localparam int Q_BIT        = 16;
    localparam int PRIO_W       = 8;

    // Byte offsets inside an entry for the state writes
    localparam int P_BYTE_OFS   = 4;
    localparam int Q_BYTE_OFS   = 5;

    localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

endpackage

// File: rtl/msi_entry_addr.sv
module msi_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int SRC_W  = 12
) (
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              tbl_en,
    input  logic [SRC_W:0]    tbl_len,
    input  logic              wide_sel,
    input  logic [SRC_W-1:0]  src,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              in_range
);
    localparam int NARROW_LG = 4;   // 16-byte entries
    localparam int WIDE_LG   = 7;   // 128-byte entries

    logic [ADDR_W-1:0] src_ext;
    logic [ADDR_W-1:0] stride_ofs;

    assign src_ext    = ADDR_W'(src);
    assign stride_ofs = wide_sel ? (src_ext << WIDE_LG) : (src_ext << NARROW_LG);
    assign entry_addr = tbl_base + stride_ofs;                    // R1
    assign in_range   = tbl_en && ({1'b0, src} < tbl_len);        // R2

endmodule

// File: rtl/msi_pq_decide.sv
module msi_pq_decide
    import msi_pq_pkg::*;
(
    input  logic [63:0]       entry,
    input  logic              force_send,
    output pq_action_e        action,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output logic              gen
);
    logic [SRV_FIELD_W-1:0] srv_field;
    logic [1:0]             pq;
    logic                   masked;
    logic                   unused_entry_bits;

    assign srv_field = entry[SRV_HI -: SRV_FIELD_W];
    assign server    = srv_field[SRV_FIELD_W-1:LINK_W];     // R3 drop link pointer
    assign prio      = entry[PRIO_W-1:0];
    assign gen       = entry[GEN_BIT];
    assign masked    = (prio == PRIO_MASKED);
    assign pq        = force_send ? 2'b00 : {entry[P_BIT], entry[Q_BIT]};   // R8

    always_comb begin
        unique case (pq)
            2'b00:   action = masked ? ACT_SET_Q : ACT_SET_P;    // R4 R5
            2'b10:   action = ACT_SET_Q;                         // R6
            default: action = ACT_DROP;                          // R7
        endcase
    end

    assign unused_entry_bits = ^{srv_field[LINK_W-1:0], entry[47:26],
                                 entry[23:17], entry[15:8]};

endmodule

// File: rtl/msi_pq_ctrl.sv
module msi_pq_ctrl
    import msi_pq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SRC_W  = 12,
    parameter int IRQ_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [SRC_W-1:0]  trig_src,
    input  logic              trig_force,
    output logic              busy,
    input  logic [ADDR_W-1:0] cfg_tbl_base,
    input  logic              cfg_tbl_en,
    input  logic [SRC_W:0]    cfg_tbl_len,
    input  logic              cfg_wide_entry,
    input  logic [IRQ_W-1:0]  cfg_irq_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [7:0]        mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [63:0]       mem_rsp_data,
    output logic              dlv_valid,
    output logic [SRV_W-1:0]  dlv_server,
    output logic [PRIO_W-1:0] dlv_prio,
    output logic [IRQ_W-1:0]  dlv_irq
);
    pq_state_e         state, state_nx;

    logic [SRC_W-1:0]  src_q;
    logic              force_q;
    logic [ADDR_W-1:0] addr_q;
    pq_action_e        act_q;
    logic [SRV_W-1:0]  srv_q;
    logic [PRIO_W-1:0] prio_q;
    logic              gen_q;

    logic [ADDR_W-1:0] ent_addr;
    logic              ent_ok;
    pq_action_e        dec_act;
    logic [SRV_W-1:0]  dec_srv;
    logic [PRIO_W-1:0] dec_prio;
    logic              dec_gen;

    logic              accept;
    logic              rsp_ok;

    msi_entry_addr #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_addr (
        .tbl_base   (cfg_tbl_base),
        .tbl_en     (cfg_tbl_en),
        .tbl_len    (cfg_tbl_len),
        .wide_sel   (cfg_wide_entry),
        .src        (trig_src),
        .entry_addr (ent_addr),
        .in_range   (ent_ok)
    );

    msi_pq_decide u_decide (
        .entry      (mem_rsp_data),
        .force_send (force_q),
        .action     (dec_act),
        .server     (dec_srv),
        .prio       (dec_prio),
        .gen        (dec_gen)
    );

    assign accept = (state == ST_IDLE) && trig_valid && ent_ok;        // R2 R10
    assign rsp_ok = (state == ST_WAIT) && mem_rsp_valid && !mem_rsp_err;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_FETCH;                   // T_ACCEPT
            ST_FETCH:   if (mem_req_ready) state_nx = ST_WAIT;            // T_READ_TAKEN
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err)             state_nx = ST_IDLE;      // T_ABORT R9
                    else if (dec_act == ACT_DROP) state_nx = ST_IDLE;     // T_DROP R7
                    else                         state_nx = ST_WRITE;     // T_UPDATE
                end
            end
            ST_WRITE: begin
                if (mem_req_ready)
                    state_nx = (act_q == ACT_SET_P) ? ST_DELIVER : ST_IDLE; // T_SEND / T_DONE
            end
            ST_DELIVER: state_nx = ST_IDLE;                               // T_DONE
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            force_q <= 1'b0;
            addr_q  <= '0;
            act_q   <= ACT_DROP;
            srv_q   <= '0;
            prio_q  <= '0;
            gen_q   <= 1'b0;
        end else begin
            if (accept) begin
                src_q   <= trig_src;
                force_q <= trig_force;
                addr_q  <= ent_addr;
            end
            if (rsp_ok) begin
                act_q  <= dec_act;
                srv_q  <= dec_srv;
                prio_q <= dec_prio;
                gen_q  <= dec_gen;
            end
        end
    end

    // Outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        mem_req_valid = (state == ST_FETCH) || (state == ST_WRITE);        // R11
        mem_req_write = (state == ST_WRITE);
        mem_req_addr  = addr_q;
        mem_req_wdata = 8'h01;
        if (state == ST_WRITE) begin
            if (act_q == ACT_SET_P) begin
                mem_req_addr  = addr_q + ADDR_W'(P_BYTE_OFS);               // R5
                mem_req_wdata = {6'b0, gen_q, 1'b1};
            end else begin
                mem_req_addr  = addr_q + ADDR_W'(Q_BYTE_OFS);               // R4 R6
            end
        end
        dlv_valid  = (state == ST_DELIVER);                                // R12
        dlv_server = srv_q;
        dlv_prio   = prio_q;
        dlv_irq    = cfg_irq_base + IRQ_W'(src_q);
    end

    // Assertions
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R11
    AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !mem_req_valid);                               // R11
    AST_DLV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !dlv_valid);                                            // R12
    AST_DLV_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_prio != PRIO_MASKED));                             // R5
    AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(src_q));                                             // R10
    AST_Q_SET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_rsp_valid && !force_q && mem_rsp_data[Q_BIT])
            |=> (state == ST_IDLE));                                          // R7
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_rsp_valid && mem_rsp_err)
            |=> (state == ST_IDLE && !mem_req_valid));                        // R9
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cfg_tbl_en) |=> !mem_req_valid);                // R2

endmodule

// File: tb/test_msi_pq_ctrl.sv
`timescale 1ns/1ps
module test_msi_pq_ctrl;

    localparam int ADDR_W = 32;
    localparam int SRC_W  = 12;
    localparam int IRQ_W  = 20;
    localparam logic [31:0] BASE = 32'h0000_0400;
    localparam logic [19:0] IRQB = 20'h00100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              trig_valid = 1'b0;
    logic [SRC_W-1:0]  trig_src = '0;
    logic              trig_force = 1'b0;
    logic              busy;
    logic [ADDR_W-1:0] cfg_tbl_base = BASE;
    logic              cfg_tbl_en = 1'b1;
    logic [SRC_W:0]    cfg_tbl_len = 13'd6;
    logic              cfg_wide_entry = 1'b0;
    logic [IRQ_W-1:0]  cfg_irq_base = IRQB;
    logic              mem_req_valid, mem_req_write;
    logic              mem_req_ready;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [7:0]        mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic              mem_rsp_err = 1'b0;
    logic [63:0]       mem_rsp_data = '0;
    logic              dlv_valid;
    logic [13:0]       dlv_server;
    logic [7:0]        dlv_prio;
    logic [IRQ_W-1:0]  dlv_irq;

    msi_pq_ctrl #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .IRQ_W(IRQ_W)) i_msi_pq_ctrl (
        .clk, .rst_n, .trig_valid, .trig_src, .trig_force, .busy,
        .cfg_tbl_base, .cfg_tbl_en, .cfg_tbl_len, .cfg_wide_entry, .cfg_irq_base,
        .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
        .mem_rsp_valid, .mem_rsp_err, .mem_rsp_data,
        .dlv_valid, .dlv_server, .dlv_prio, .dlv_irq
    );

    // Memory model
    logic [7:0]  mem [0:4095];
    logic [31:0] cyc = 0;
    logic        stall = 1'b0;
    logic        inj_err = 1'b0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_rd_addr = '0;

    assign mem_req_ready = stall ? cyc[0] : 1'b1;

    function automatic logic [63:0] rd64(input logic [31:0] a);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[63-8*k -: 8] = mem[(a + k) & 32'hFFF];
        return v;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[11:0]] <= mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt        <= rd_cnt + 1;
                last_rd_addr  <= mem_req_addr;
                mem_rsp_valid <= 1'b1;
                mem_rsp_err   <= inj_err;
                mem_rsp_data  <= rd64(mem_req_addr);
            end
        end
    end

    // Delivery and overlap monitor
    int          dlv_cnt = 0;
    int          overlap = 0;
    logic [13:0] seen_srv;
    logic [7:0]  seen_prio;
    logic [19:0] seen_irq;
    always @(negedge clk) begin
        if (dlv_valid) begin
            dlv_cnt++;
            seen_srv  = dlv_server;
            seen_prio = dlv_prio;
            seen_irq  = dlv_irq;
        end
        if (mem_req_valid && mem_rsp_valid) overlap++;
    end

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_entry(input logic [31:0] a, input logic [63:0] v);
        for (int k = 0; k < 8; k++) mem[(a + k) & 32'hFFF] = v[63-8*k -: 8];
    endtask

    task automatic fire(input logic [SRC_W-1:0] s, input bit f);
        @(negedge clk);
        trig_valid = 1'b1; trig_src = s; trig_force = f;
        @(negedge clk);
        trig_valid = 1'b0; trig_force = 1'b0;
        while (busy) @(negedge clk);
    endtask

    function automatic logic [63:0] mk_entry(input int s, input int pq, input bit gen,
                                             input logic [15:0] srvf, input logic [7:0] pr);
        return {srvf, 16'hA500 + 16'(s), 6'b0, gen, 1'(pq >> 1), 7'b0, 1'(pq & 1), 8'h00, pr};
    endfunction

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        // Reset state
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_req_valid == 0 && dlv_valid == 0, "R11 R12 reset outputs",
            {61'b0, busy, mem_req_valid, dlv_valid}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Sweep: source x entry size x P/Q x mask x force
        for (int s = 0; s < 6; s++)
        for (int big = 0; big < 2; big++)
        for (int pq = 0; pq < 4; pq++)
        for (int m = 0; m < 2; m++)
        for (int f = 0; f < 2; f++) begin
            bit          gen;
            logic [7:0]  pr;
            logic [15:0] srvf;
            logic [31:0] ea;
            logic [63:0] ent, exp_ent;
            int          epq, act, rd0, dl0;
            string       tag;
            gen  = 1'((s + pq) & 1);
            pr   = m ? 8'hFF : 8'(8'h10 + s * 3 + pq);
            srvf = 16'(16'h1200 + s * 32 + pq * 4 + m * 2 + f);
            ea   = BASE + 32'(big ? s * 128 : s * 16);
            ent  = mk_entry(s, pq, gen, srvf, pr);
            stall = 1'((s + big + pq + m + f) & 1);
            cfg_wide_entry = 1'(big);
            put_entry(ea, ent);
            rd0 = rd_cnt; dl0 = dlv_cnt;
            fire(12'(s), 1'(f));
            epq = f ? 0 : pq;
            act = (epq == 0) ? (m ? 1 : 2) : (epq == 2 ? 1 : 0);
            exp_ent = ent;
            if (act == 1) exp_ent[23:16] = 8'h01;
            if (act == 2) exp_ent[31:24] = {6'b0, gen, 1'b1};
            tag = (f && pq != 0) ? "R8 forced" :
                  (act == 2 ? "R5 set P" : (epq == 0 ? "R4 masked set Q" :
                  (epq == 2 ? "R6 set Q" : "R7 drop")));
            chk(rd_cnt == rd0 + 1 && last_rd_addr == ea, "R1 entry address",
                {32'b0, last_rd_addr}, {32'b0, ea});
            chk(rd64(ea) == exp_ent, {tag, " entry bytes"}, rd64(ea), exp_ent);
            chk(dlv_cnt - dl0 == (act == 2 ? 1 : 0), {tag, " R12 delivery count"},
                64'(dlv_cnt - dl0), (act == 2) ? 64'd1 : 64'd0);
            if (act == 2)
                chk(seen_srv == srvf[15:2] && seen_prio == pr && seen_irq == IRQB + 20'(s),
                    "R3 R5 delivered fields", {22'b0, seen_srv, seen_prio, seen_irq},
                    {22'b0, srvf[15:2], pr, IRQB + 20'(s)});
        end
        stall = 1'b0;
        cfg_wide_entry = 1'b0;

        // Bounds: sources at and above the length
        for (int s = 6; s < 8; s++) begin
            int rd0;
            rd0 = rd_cnt;
            fire(12'(s), 1'b0);
            @(negedge clk);
            chk(rd_cnt == rd0 && !busy, "R2 out of range", 64'(rd_cnt - rd0), 64'd0);
        end

        // Disabled table
        begin
            int rd0;
            cfg_tbl_en = 1'b0;
            rd0 = rd_cnt;
            fire(12'd0, 1'b1);
            @(negedge clk);
            chk(rd_cnt == rd0 && !busy, "R2 table disabled", 64'(rd_cnt - rd0), 64'd0);
            cfg_tbl_en = 1'b1;
        end

        // Read error aborts
        begin
            logic [63:0] ent;
            int wr0, dl0;
            ent = mk_entry(3, 0, 1'b1, 16'h2345, 8'h22);
            put_entry(BASE + 32'd48, ent);
            inj_err = 1'b1; wr0 = wr_cnt; dl0 = dlv_cnt;
            fire(12'd3, 1'b0);
            inj_err = 1'b0;
            chk(wr_cnt == wr0 && dlv_cnt == dl0 && rd64(BASE + 32'd48) == ent,
                "R9 read error abort", rd64(BASE + 32'd48), ent);
        end

        // Triggers while busy are ignored
        begin
            logic [63:0] e1, e2;
            int dl0;
            e1 = mk_entry(1, 0, 1'b0, 16'h3004, 8'h31);
            e2 = mk_entry(2, 0, 1'b0, 16'h3008, 8'h32);
            put_entry(BASE + 32'd16, e1);
            put_entry(BASE + 32'd32, e2);
            dl0 = dlv_cnt;
            @(negedge clk);
            trig_valid = 1'b1; trig_src = 12'd1;
            @(negedge clk);
            trig_src = 12'd2;
            @(negedge clk);
            @(negedge clk);
            trig_valid = 1'b0;
            while (busy) @(negedge clk);
            @(negedge clk);
            chk(rd64(BASE + 32'd32) == e2, "R10 busy trigger left entry", rd64(BASE + 32'd32), e2);
            chk(dlv_cnt - dl0 == 1 && seen_irq == IRQB + 20'd1, "R10 single delivery",
                64'(dlv_cnt - dl0), 64'd1);
        end

        chk(overlap == 0, "R11 one request in flight", 64'(overlap), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=idle");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule